// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side engine that answers burst reads from a word-addressed memory array placed behind a multiplexed address/data bus. A host writes a 16-bit read configuration word. Opening a bus cycle means holding chip enable low while pulsing the address-valid strobe. The sequencer captures the start address, counts out the programmed latency and places words on the bus. It also produces a WAIT handshake that tells the host in which clocks the bus carries valid data.

The configuration selects between a single-word asynchronous read and a synchronous burst. It also sets the latency, the WAIT level, whether WAIT leads the data by a clock, one-clock or two-clock data hold, and linear or wrapped addressing inside a 4, 8 or 16 word window. At long latencies with one-clock hold, the sequencer pauses for a few clocks after every group of four words. The array is a registered lookup with a one-clock access delay.

Cycle numbering used below: cycle 0 is the clock that follows the rising edge on which chip enable and the strobe are both sampled low. Cycle k comes k clocks later. L is the latency code, H is the hold length in clocks, and S is the stall length.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads back 0xBFCF. Field positions: bit 15 asynchronous-read select, bits 13:11 latency code, bit 10 WAIT active-high, bit 9 two-clock hold, bit 8 early WAIT, bit 7 linear order (reads 1), bit 6 clock-edge select, bit 3 no-wrap, bits 2:0 burst length. A legal write, including any clock-edge value, reads back as written.
- R2: A write is dropped and the old value kept if it carries latency code 0 or 1, or a burst-length code other than 001, 010, 011 or 111. Bits 14, 5 and 4 always read 0 and bit 7 always reads 1.
- R3: With bit 15 set, data_oe is high from cycle 1, the bus carries the start word for as long as chip enable stays low, and WAIT stays at its deasserted level.
- R4: With bit 15 clear, the start word is on the bus from cycle 1. Cycle L is the first valid data cycle.
- R5: Each burst word stays valid for H clocks: H is 2 when bit 9 is set and 1 when it is clear.
- R6: With one-clock hold and L equal to 5, 6 or 7, S = L-4 non-valid clocks follow every fourth word, counted from the burst start. With two-clock hold, or with L of 4 or less, there are no stalls.
- R7: In a burst, WAIT is asserted in every non-valid clock (latency and stall). With bit 8 set, WAIT runs one clock early: it is asserted in cycle k exactly when cycle k+1 is not valid.
- R8: WAIT is driven high when asserted if bit 10 is 1, and low when asserted if bit 10 is 0. Outside a burst it is held at the deasserted level.
- R9: Burst word n reads address start+n (modulo 2^AW) when bit 3 is 1 or the length code is 111.
- R10: When bit 3 is 0 and the length is 4, 8 or 16 words, word n reads address (start with its low log2(len) bits cleared) OR ((start+n) mod len).
- R11: Raising chip enable ends the burst at once: data_oe falls in the same clock and WAIT returns to the deasserted level.
- R12: The array word at address a is {a[15:8] XOR ~a[7:0], a[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read-back |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Burst start word address |
| data_out | output | DW | Data bus value |
| data_oe | output | 1 | Data bus drive enable |
| wait_out | output | 1 | WAIT handshake |

## Verification
The bench targets the clock at which each stall begins and ends for latency codes 5, 6 and 7. A design that counted stalls from an address boundary rather than from the burst start, or that kept stalling under two-clock hold, would hand the host a word one clock early or late. It also checks the first clocks of every burst: the flow-through start word, and WAIT leading the data by exactly one clock in early mode. An off-by-one in the latency counter appears there as a shifted WAIT edge. Wrapped bursts start in the middle of 4, 8 and 16 word windows, so a window mask of the wrong size would leak into the next window. Rejected configuration writes are read back to show that a partial update never lands.

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the burst read sequencer.
// Assumes a 16-bit configuration word with the field layout given in the brief.
package brs_pkg;

    typedef enum logic [1:0] {PH_LAT, PH_DATA, PH_STALL} phase_e;

    typedef struct packed {
        logic       async_rd;
        logic [2:0] lat;
        logic       wait_hi;
        logic       hold2;
        logic       wait_early;
        logic       edge_rise;
        logic       no_wrap;
        logic [2:0] blen;
    } cfg_t;

    localparam logic [15:0] CFG_RESET = 16'hBFCF;

    // Split a configuration word into fields.
    function automatic cfg_t unpack_cfg(input logic [15:0] w);
        cfg_t c;
        c.async_rd   = w[15];
        c.lat        = w[13:11];
        c.wait_hi    = w[10];
        c.hold2      = w[9];
        c.wait_early = w[8];
        c.edge_rise  = w[6];
        c.no_wrap    = w[3];
        c.blen       = w[2:0];
        return c;
    endfunction

    // Rebuild the read-back word; fixed bits are forced.
    function automatic logic [15:0] pack_cfg(input cfg_t c);
        return {c.async_rd, 1'b0, c.lat, c.wait_hi, c.hold2, c.wait_early,
                1'b1, c.edge_rise, 2'b00, c.no_wrap, c.blen};
    endfunction

    function automatic logic lat_ok(input logic [2:0] l);
        return l >= 3'd2;
    endfunction

    function automatic logic blen_ok(input logic [2:0] b);
        return (b == 3'b001) || (b == 3'b010) || (b == 3'b011) || (b == 3'b111);
    endfunction

    // Low-bit mask of the wrap window; zero for continuous length.
    function automatic logic [4:0] win_mask(input logic [2:0] b);
        case (b)
            3'b001:  return 5'd3;
            3'b010:  return 5'd7;
            3'b011:  return 5'd15;
            default: return 5'd0;
        endcase
    endfunction

    // Array content for a word address.
    function automatic logic [15:0] word_of(input logic [15:0] a);
        return {a[15:8] ^ ~a[7:0], a[7:0]};
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
`timescale 1ns/1ps
// Read configuration register.
// Holds the configuration fields, rejects whole writes with reserved latency
// or length codes, and presents a read-back word with fixed bits forced.
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        async_rd,
    output logic [2:0]  lat,
    output logic        wait_hi,
    output logic        hold2,
    output logic        wait_early,
    output logic        no_wrap,
    output logic [2:0]  blen
);
    cfg_t cfg_q;

    // Load legal writes only; a reserved code drops the whole write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= unpack_cfg(CFG_RESET);
        end else if (we && lat_ok(wdata[13:11]) && blen_ok(wdata[2:0])) begin
            cfg_q <= unpack_cfg(wdata);
        end
    end

    assign rdata      = pack_cfg(cfg_q);
    assign async_rd   = cfg_q.async_rd;
    assign lat        = cfg_q.lat;
    assign wait_hi    = cfg_q.wait_hi;
    assign hold2      = cfg_q.hold2;
    assign wait_early = cfg_q.wait_early;
    assign no_wrap    = cfg_q.no_wrap;
    assign blen       = cfg_q.blen;

    // R2
    rsvd_lat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !lat_ok(wdata[13:11])) |=> $stable(rdata));

    // R2
    rsvd_len_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !blen_ok(wdata[2:0])) |=> $stable(rdata));

    // R1
    lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_ok(cfg_q.lat) && blen_ok(cfg_q.blen));

endmodule

// File: rtl/brs_timing.sv
`timescale 1ns/1ps
// Burst timing engine.
// Counts latency, paces each word for one or two clocks, inserts the
// stall clocks after every fourth word, and produces the WAIT request.
// Assumes the configuration is not rewritten during a burst.
module brs_timing
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          sync_mode,
    input  logic [2:0]    lat,
    input  logic          hold2,
    input  logic          wait_early,
    output logic          primed,
    output logic          wait_req,
    output logic [AW-1:0] nidx
);
    localparam logic [AW-1:0] IDX_ONE = AW'(1);

    phase_e        phase, n_phase;
    logic          active;
    logic [2:0]    tcnt, n_t;
    logic          hcnt, n_h;
    logic [1:0]    scnt, n_s;
    logic [AW-1:0] idx, n_idx;
    logic [2:0]    stall_full;
    logic [1:0]    stall_len;

    // Stall length: L-4 for codes 5..7 with one-clock hold, else none.
    always_comb begin
        stall_full = lat - 3'd4;
        stall_len  = (!hold2 && lat >= 3'd5) ? stall_full[1:0] : 2'd0;
    end

    // Next-state of the burst, ignoring a new strobe.
    always_comb begin
        n_phase = phase;
        n_t     = tcnt;
        n_h     = hcnt;
        n_s     = scnt;
        n_idx   = idx;
        case (phase)
            PH_LAT: begin
                if (sync_mode && tcnt == lat - 3'd1) begin
                    n_phase = PH_DATA;
                    n_h     = 1'b0;
                end else if (tcnt != 3'd7) begin
                    n_t = tcnt + 3'd1;
                end
            end
            PH_DATA: begin
                if (hcnt == hold2) begin
                    n_idx = idx + IDX_ONE;
                    n_h   = 1'b0;
                    if (stall_len != 2'd0 && idx[1:0] == 2'b11) begin
                        n_phase = PH_STALL;
                        n_s     = 2'd0;
                    end
                end else begin
                    n_h = 1'b1;
                end
            end
            PH_STALL: begin
                if (scnt == stall_len - 2'd1) begin
                    n_phase = PH_DATA;
                    n_h     = 1'b0;
                end else begin
                    n_s = scnt + 2'd1;
                end
            end
            default: n_phase = PH_LAT;
        endcase
    end

    // Burst state: restart on strobe, stop on chip disable, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            primed <= 1'b0;
            phase  <= PH_LAT;
            tcnt   <= 3'd0;
            hcnt   <= 1'b0;
            scnt   <= 2'd0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            primed <= 1'b0;
            phase  <= PH_LAT;
            tcnt   <= 3'd0;
            hcnt   <= 1'b0;
            scnt   <= 2'd0;
            idx    <= '0;
        end else if (stop) begin
            active <= 1'b0;
            primed <= 1'b0;
        end else if (active) begin
            primed <= 1'b1;
            phase  <= n_phase;
            tcnt   <= n_t;
            hcnt   <= n_h;
            scnt   <= n_s;
            idx    <= n_idx;
        end
    end

    assign nidx     = n_idx;
    assign wait_req = active && sync_mode &&
                      (wait_early ? (n_phase != PH_DATA) : (phase != PH_DATA));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && phase == PH_LAT && tcnt == 3'd0 && !primed));

    // R6
    no_stall_hold2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase == PH_STALL) |-> (!hold2 && lat >= 3'd5));

    // R5
    hold_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase == PH_DATA && hold2 && !hcnt && !start && !stop)
        |=> (phase == PH_DATA && idx == $past(idx)));

    // R11
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!active && !primed));

endmodule

// File: rtl/brs_addr_gen.sv
`timescale 1ns/1ps
// Burst address generator.
// Captures the start address on the strobe and maps the next word index to
// an array address, either linear or wrapped inside a 4/8/16 word window.
module brs_addr_gen
    import brs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] nidx,
    input  logic          no_wrap,
    input  logic [2:0]    blen,
    output logic [AW-1:0] rd_addr
);
    logic [AW-1:0] start_q;
    logic [AW-1:0] mask;
    logic [AW-1:0] lin;
    logic          wrap_on;

    // Latch the start address of each bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (start) begin
            start_q <= start_addr;
        end
    end

    // Pick linear or window-wrapped word address.
    always_comb begin
        mask    = {{(AW-5){1'b0}}, win_mask(blen)};
        wrap_on = !no_wrap && (blen != 3'b111);
        lin     = start_q + nidx;
        rd_addr = wrap_on ? ((start_q & ~mask) | (lin & mask)) : lin;
    end

    // R10
    wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_on |-> (((rd_addr ^ start_q) & ~mask) == '0));

endmodule

// File: rtl/brs_array.sv
`timescale 1ns/1ps
// Memory array model: registered lookup with a one-clock access delay.
// Content is computed from the address; assumes AW and DW are 16.
module brs_array
    import brs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    // Register the looked-up word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else begin
            data <= DW'(word_of(16'(addr)));
        end
    end
endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
// Synchronous burst read sequencer, top level.
// Ties the configuration register, timing engine, address generator and
// array together and drives the bus enable and WAIT level.
// Assumes all inputs are synchronous to clk.
module burst_read_seq
    import brs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          wait_out
);
    logic          async_rd, wait_hi, hold2, wait_early, no_wrap;
    logic [2:0]    lat, blen;
    logic          start, primed, wait_req;
    logic [AW-1:0] nidx, rd_addr;

    assign start = !ce_n && !adv_n;

    brs_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .async_rd(async_rd), .lat(lat), .wait_hi(wait_hi),
        .hold2(hold2), .wait_early(wait_early), .no_wrap(no_wrap), .blen(blen)
    );

    brs_timing #(.AW(AW)) u_tim (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(ce_n),
        .sync_mode(!async_rd), .lat(lat), .hold2(hold2),
        .wait_early(wait_early), .primed(primed), .wait_req(wait_req),
        .nidx(nidx)
    );

    brs_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(addr_in),
        .nidx(nidx), .no_wrap(no_wrap), .blen(blen), .rd_addr(rd_addr)
    );

    brs_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .addr(rd_addr), .data(data_out)
    );

    // Bus drive and WAIT level; chip disable takes effect at once.
    always_comb begin
        data_oe  = primed && !ce_n;
        wait_out = (wait_req && !ce_n) ? wait_hi : !wait_hi;
    end

    // R3
    async_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_rd |-> (wait_out == !wait_hi));

endmodule

// File: tb/sim_burst_read_seq.sv
`timescale 1ns/1ps
module sim_burst_read_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic          wait_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        logic        oe;
        logic        wt;
        logic        cd;
        logic [15:0] d;
        string       tag;
    } rec_t;
    rec_t exp_q[$];

    // Bench copy of the configuration
    logic       m_rm = 1, m_wp = 1, m_dh = 1, m_wd = 1, m_bw = 1;
    logic [2:0] m_lc = 3'd7, m_bl = 3'b111;

    always #10 clk = ~clk;

    burst_read_seq #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
        .data_out(data_out), .data_oe(data_oe), .wait_out(wait_out)
    );

    function automatic logic [15:0] cfgw(logic rm, logic [2:0] lc, logic wp,
        logic dh, logic wd, logic ce, logic bw, logic [2:0] bl);
        return {rm, 1'b0, lc, wp, dh, wd, 1'b1, ce, 2'b00, bw, bl};
    endfunction

    function automatic logic [15:0] word_of(logic [15:0] a);
        return {a[15:8] ^ ~a[7:0], a[7:0]};
    endfunction

    function automatic logic [15:0] addr_of(logic [15:0] s, int n);
        logic [15:0] m;
        logic [15:0] lin;
        m   = (m_bl == 3'b001) ? 16'd3 : (m_bl == 3'b010) ? 16'd7 :
              (m_bl == 3'b011) ? 16'd15 : 16'd0;
        lin = s + 16'(n);
        if (!m_bw && m != 0) return (s & ~m) | (lin & m);
        return lin;
    endfunction

    // Index of the word valid in cycle k, or -1 when not valid.
    function automatic int idx_at(int k);
        int h, s, per, r, w;
        h = m_dh ? 2 : 1;
        s = (!m_dh && m_lc >= 5) ? int'(m_lc) - 4 : 0;
        if (k < int'(m_lc)) return -1;
        r   = k - int'(m_lc);
        per = 4 * h + s;
        w   = r % per;
        if (w >= 4 * h) return -1;
        return (r / per) * 4 + w / h;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        if (w[13:11] >= 3'd2 &&
            (w[2:0] == 3'b001 || w[2:0] == 3'b010 || w[2:0] == 3'b011 || w[2:0] == 3'b111)) begin
            m_rm = w[15]; m_lc = w[13:11]; m_wp = w[10]; m_dh = w[9];
            m_wd = w[8];  m_bw = w[3];     m_bl = w[2:0];
        end
    endtask

    // Driver: open a bus cycle, queue expected per-cycle results, close it.
    task automatic run_burst(logic [15:0] s, int n, string tag);
        @(negedge clk);
        ce_n = 1'b0;
        adv_n = 1'b0;
        addr_in = s;
        for (int k = 0; k < n; k++) begin
            rec_t r;
            int v;
            logic asrt;
            r.tag = tag;
            r.oe  = (k >= 1);
            if (m_rm) begin
                r.wt = ~m_wp;
                r.cd = (k >= 1);
                r.d  = word_of(s);
            end else begin
                v    = idx_at(k);
                asrt = m_wd ? (idx_at(k + 1) < 0) : (v < 0);
                r.wt = asrt ? m_wp : ~m_wp;
                r.cd = (k >= 1) && (k < int'(m_lc) || v >= 0);
                r.d  = (k < int'(m_lc)) ? word_of(s) : word_of(addr_of(s, v));
            end
            exp_q.push_back(r);
        end
        @(negedge clk);
        adv_n = 1'b1;
        repeat (n - 1) @(negedge clk);
        ce_n = 1'b1;
        #1;
        check("R11 oe drops on chip disable", {15'd0, data_oe}, 16'd0);
        check("R11 R8 WAIT idle level", {15'd0, wait_out}, {15'd0, ~m_wp});
    endtask

    // Monitor: compare each queued cycle a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                rec_t r;
                r = exp_q.pop_front();
                n_checks++;
                if (data_oe !== r.oe || wait_out !== r.wt ||
                    (r.cd && data_out !== r.d)) begin
                    n_errors++;
                    $display("FAIL %s: actual oe=%b wait=%b data=%h expected oe=%b wait=%b data=%h%s",
                             r.tag, data_oe, wait_out, data_out, r.oe, r.wt, r.d,
                             r.cd ? "" : " (data unchecked)");
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value, R11 idle bus
        check("R1 reset config", cfg_rdata, 16'hBFCF);
        check("R11 idle oe", {15'd0, data_oe}, 16'd0);
        check("R8 idle WAIT", {15'd0, wait_out}, 16'd0);

        // R3 asynchronous single word, R12 content
        run_burst(16'h0040, 6, "R3 R12 async");

        // R4 R9 R12: latency 2, one-clock hold, late WAIT, linear
        write_cfg(cfgw(0, 3'd2, 1, 0, 0, 1, 1, 3'b111));
        check("R1 readback", cfg_rdata, cfgw(0, 3'd2, 1, 0, 0, 1, 1, 3'b111));
        run_burst(16'h0010, 12, "R4 R9 R12 lat2");

        // R6 R7 R8: latency 7 stalls of 3, early WAIT, active-low WAIT
        write_cfg(cfgw(0, 3'd7, 0, 0, 1, 1, 1, 3'b111));
        run_burst(16'h00FE, 30, "R6 R7 R8 lat7");

        // R6 R10: latency 5 stalls of 1, wrap in 4
        write_cfg(cfgw(0, 3'd5, 1, 0, 0, 1, 0, 3'b001));
        run_burst(16'h000E, 20, "R6 R10 wrap4");

        // R5 R6 R10: latency 6 two-clock hold (no stalls), wrap in 8, early WAIT
        write_cfg(cfgw(0, 3'd6, 1, 1, 1, 1, 0, 3'b010));
        run_burst(16'h001D, 30, "R5 R6 R10 wrap8");

        // R10: latency 3, wrap in 16
        write_cfg(cfgw(0, 3'd3, 1, 0, 0, 1, 0, 3'b011));
        run_burst(16'h0127, 24, "R10 wrap16");

        // R9 R5: no-wrap with length 4 runs linear; falling-edge bit read back
        write_cfg(cfgw(0, 3'd4, 1, 1, 0, 0, 1, 3'b001));
        check("R1 edge bit readback", cfg_rdata, cfgw(0, 3'd4, 1, 1, 0, 0, 1, 3'b001));
        run_burst(16'h0036, 16, "R9 R5 nowrap4");

        // R2 reserved codes ignored
        keep = cfg_rdata;
        write_cfg(cfgw(0, 3'd1, 0, 0, 1, 1, 0, 3'b010));
        check("R2 reserved latency ignored", cfg_rdata, keep);
        write_cfg(cfgw(1, 3'd5, 0, 0, 1, 1, 0, 3'b101));
        check("R2 reserved length ignored", cfg_rdata, keep);
        // R2 fixed bits: write with 14, 5, 4 set and bit 7 clear
        write_cfg(16'h4030 | cfgw(0, 3'd2, 1, 0, 0, 1, 1, 3'b111) & ~16'h0080);
        check("R2 fixed bits", cfg_rdata, cfgw(0, 3'd2, 1, 0, 0, 1, 1, 3'b111));

        // R4: a short burst after the fixed-bit write still runs at latency 2
        run_burst(16'h0200, 6, "R4 R9 after fixed-bit write");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule